// File: doc/BRIEF.md
# First-Come Channel Request Queue

This block decides the order in which eight data channels are offered the data slot of a round-robin bus arbiter. There are three video channels, four audio channels and one peripheral-interface channel. Each channel watches the fill level of its own FIFO, which is held outside this block. When the level reaches that channel's programmed Dword threshold, the channel's index is appended to a first-come first-serve queue. The arbiter reads the index at the head, runs the burst for that channel and then pops the entry.

A video channel that finishes a job may need to flush a partly filled FIFO. A one-cycle job-done pulse makes that channel eligible even below its threshold. This eligibility is held until the channel is queued or its FIFO reads empty. Each channel has a lock bit. The bit is set when the channel is queued and cleared when its entry is popped, so a channel never has more than one entry. Because of this, the eight-slot queue cannot overflow.

Top module: `chan_req_queue`

## Requirements
- R1: After a synchronous active-low reset, `not_empty` is 0, no channel is locked and no flush is pending.
- R2: A channel with `xfer_en` set and no entry in the queue is appended on the next rising clock edge when its fill level is greater than or equal to its own threshold. A level one below the threshold does not append it.
- R3: A channel has at most one entry in the queue, and the queue never holds more than eight entries.
- R4: `head_id` is the oldest entry. A pop while `not_empty` is 1 removes exactly that entry. Appends never change a non-empty head.
- R5: Channels that become eligible on the same edge are appended in ascending channel-index order.
- R6: A `vid_done` pulse for video channel v makes v eligible on that edge and on later edges, even below threshold, while its fill level is non-zero. The pending flush clears when v is appended or when its fill level is zero.
- R7: A channel's lock clears on the edge that pops its entry. The channel can be appended again on the following edge.
- R8: A channel with `xfer_en` at 0 is not appended. An entry that is already queued stays in place when `xfer_en` falls.
- R9: A pop while the queue is empty has no effect.
- R10: Channel index encoding on `head_id`: 0 to 2 are video channels 1 to 3, 3 to 6 are audio channels 1 to 4, and 7 is the peripheral channel. Channel i's fill level and threshold are bits [8i+7:8i] of their buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_lvl | input | 64 | Per-channel FIFO fill level in Dwords, 8 bits per channel |
| thresh | input | 64 | Per-channel append threshold in Dwords, 8 bits per channel |
| xfer_en | input | 8 | Per-channel transfer enable |
| vid_done | input | 3 | Per-video-channel job-done pulse |
| pop | input | 1 | Arbiter has served the head entry |
| head_id | output | 3 | Channel index at the head of the queue (0 when empty) |
| not_empty | output | 1 | Queue holds at least one entry |

## Verification
The assertions rely on the arbiter popping only the entry shown on `head_id`. They also rely on the thresholds staying constant while a channel sits near its crossing point. No assumption is made about `pop` while the queue is empty, because that case is defined to be ignored. The stimulus changes every input on the falling clock edge and keeps the thresholds fixed, except during one directed step. It also issues pops only when the bench's own expected queue is non-empty, apart from the deliberate empty-pop cases.

// File: rtl/cq_pkg.sv
// Shared sizing for the channel request queue.
// Assumes channel order video, then audio, then peripheral.
package cq_pkg;
    localparam int NUM_VID = 3;
    localparam int NUM_AUD = 4;
    localparam int NUM_PER = 1;
    localparam int NUM_CH  = NUM_VID + NUM_AUD + NUM_PER;
    localparam int LVL_W   = 8;
endpackage

// File: rtl/cq_elig.sv
// Per-channel eligibility: threshold compare plus held flush request
// for video channels. Assumes every asserted want bit is appended on
// the same edge by the ring.
module cq_elig #(
    parameter int NCH   = cq_pkg::NUM_CH,
    parameter int NVID  = cq_pkg::NUM_VID,
    parameter int LVL_W = cq_pkg::LVL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*LVL_W-1:0] fill_lvl,
    input  logic [NCH*LVL_W-1:0] thresh,
    input  logic [NCH-1:0]       xfer_en,
    input  logic [NVID-1:0]      vid_done,
    input  logic [NCH-1:0]       lock,
    output logic [NCH-1:0]       want
);
    logic [NVID-1:0] flush_pend;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [LVL_W-1:0] lvl, thr;
        logic             hit;
        assign lvl = fill_lvl[i*LVL_W +: LVL_W];
        assign thr = thresh[i*LVL_W +: LVL_W];
        if (i < NVID) begin : g_vid
            logic flush_now;
            // Flush request: new pulse or one held from earlier.
            assign flush_now = (flush_pend[i] | vid_done[i]) & (lvl != '0);
            assign hit = (lvl >= thr) | flush_now;
            // Hold the flush request until appended or FIFO empty.
            always_ff @(posedge clk) begin
                if (!rst_n) flush_pend[i] <= 1'b0;
                else        flush_pend[i] <= flush_now & ~want[i];
            end
            // r6_ a held flush only survives while the FIFO has data
            a_r6_pend_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
                flush_pend[i] |-> $past(lvl) != '0);
        end else begin : g_oth
            assign hit = (lvl >= thr);
        end
        // Eligibility gated by enable and lock.
        assign want[i] = hit & xfer_en[i] & ~lock[i];
    end
endmodule

// File: rtl/cq_lock.sv
// Per-channel lock bits: set when a channel is appended, cleared when
// its entry is popped. Assumes pop refers to the current head entry.
module cq_lock #(
    parameter int NCH  = cq_pkg::NUM_CH,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  set_v,
    input  logic            pop_eff,
    input  logic [CH_W-1:0] pop_id,
    output logic [NCH-1:0]  lock
);
    logic [NCH-1:0] clr_v;

    // One-hot clear for the popped channel.
    always_comb begin
        clr_v = '0;
        if (pop_eff) clr_v[pop_id] = 1'b1;
    end

    // Lock register update.
    always_ff @(posedge clk) begin
        if (!rst_n) lock <= '0;
        else        lock <= (lock | set_v) & ~clr_v;
    end

    // r3_ a lock may only be taken by an unlocked channel
    a_r3_set_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v & lock) == '0);
    // r7_ the popped channel must have been locked
    a_r7_pop_locked: assert property (@(posedge clk) disable iff (!rst_n)
        pop_eff |-> lock[pop_id]);
endmodule

// File: rtl/cq_ring.sv
// Circular queue of channel indices with many appends per cycle in
// ascending index order and one pop. Assumes the lock scheme keeps
// total occupancy within DEPTH.
module cq_ring #(
    parameter int NCH   = cq_pkg::NUM_CH,
    parameter int DEPTH = NCH,
    parameter int CH_W  = $clog2(NCH),
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  push_v,
    input  logic            pop,
    output logic [CH_W-1:0] head,
    output logic [CW-1:0]   count,
    output logic            pop_eff
);
    logic [CH_W-1:0] mem [DEPTH];
    logic [PW-1:0]   rd_ptr;
    logic [CW-1:0]   offs [NCH];
    logic [CW-1:0]   n_push;

    assign pop_eff = pop & (count != '0);
    assign head    = (count != '0) ? mem[rd_ptr] : '0;

    // Prefix count gives each appending channel its slot offset.
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            offs[i] = acc;
            acc     = acc + CW'(push_v[i]);
        end
        n_push = acc;
    end

    // Storage, read pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (push_v[i])
                    mem[PW'((int'(rd_ptr) + int'(count) + int'(offs[i])) % DEPTH)] <= CH_W'(i);
            end
            if (pop_eff) rd_ptr <= PW'((int'(rd_ptr) + 1) % DEPTH);
            count <= count + n_push - CW'(pop_eff);
        end
    end

    // r3_ appends never exceed the free space
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(n_push) + int'(count) - int'(pop_eff) <= DEPTH);
    // r4_ head holds while nobody pops
    a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && !pop) |=> $stable(head) && count != '0);
    // r9_ empty pop with no append leaves the queue empty
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && push_v == '0) |=> count == '0);
endmodule

// File: rtl/chan_req_queue.sv
// Top: first-come queue of data-channel requests feeding the data slot
// of a round-robin bus arbiter. Assumes the arbiter pops only the entry
// shown on head_id.
module chan_req_queue #(
    parameter int NCH   = cq_pkg::NUM_CH,
    parameter int NVID  = cq_pkg::NUM_VID,
    parameter int LVL_W = cq_pkg::LVL_W,
    parameter int CH_W  = $clog2(NCH),
    parameter int CW    = $clog2(NCH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*LVL_W-1:0] fill_lvl,
    input  logic [NCH*LVL_W-1:0] thresh,
    input  logic [NCH-1:0]       xfer_en,
    input  logic [NVID-1:0]      vid_done,
    input  logic                 pop,
    output logic [CH_W-1:0]      head_id,
    output logic                 not_empty
);
    logic [NCH-1:0] want, lock;
    logic [CW-1:0]  count;
    logic           pop_eff;

    cq_elig #(.NCH(NCH), .NVID(NVID), .LVL_W(LVL_W)) elig_i (
        .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .thresh(thresh),
        .xfer_en(xfer_en), .vid_done(vid_done), .lock(lock), .want(want));

    cq_lock #(.NCH(NCH), .CH_W(CH_W)) lock_i (
        .clk(clk), .rst_n(rst_n), .set_v(want), .pop_eff(pop_eff),
        .pop_id(head_id), .lock(lock));

    cq_ring #(.NCH(NCH), .DEPTH(NCH), .CH_W(CH_W), .CW(CW)) ring_i (
        .clk(clk), .rst_n(rst_n), .push_v(want), .pop(pop),
        .head(head_id), .count(count), .pop_eff(pop_eff));

    assign not_empty = (count != '0);

    // r3_ one entry per locked channel, none for unlocked ones
    a_r3_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) == $countones(lock));
    // r8_ a disabled channel never takes a new lock
    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock[0] && !xfer_en[0]) |=> !lock[0]);
    // r1_ reset leaves the queue empty
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> !not_empty && lock == '0);
endmodule

// File: tb/chan_req_queue_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for enable, held flush, threshold boundary and reset.
module chan_req_queue_tb_top;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [63:0] fill;
        logic [2:0]  done;
        logic        pop;
        logic        ne;
        logic [2:0]  head;
    } vec_t;

    // Thresholds are 8 for every channel; 'h10 is above, 'h04 below.
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_1000_0000, 3'b000, 1'b0, 1'b1, 3'd3}, // R2 ch3 appended
        '{64'h0010_0000_1000_1000, 3'b000, 1'b0, 1'b1, 3'd3}, // R5 1,6 after 3; R3 3 locked
        '{64'h0010_0000_0000_1000, 3'b000, 1'b1, 1'b1, 3'd1}, // R4 pop 3
        '{64'h1000_0000_1000_0010, 3'b000, 1'b0, 1'b1, 3'd1}, // R5 0,3,7; R7 3 again
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd6},                   // R4
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd0},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd3},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd7},
        '{64'h0, 3'b000, 1'b1, 1'b0, 3'd0},                   // R4 drained
        '{64'h0, 3'b000, 1'b1, 1'b0, 3'd0},                   // R9 empty pop
        '{64'h0000_0000_0004_0000, 3'b100, 1'b0, 1'b1, 3'd2}, // R6 flush below thr
        '{64'h0808_0808_0808_0808, 3'b000, 1'b0, 1'b1, 3'd2}, // R2 equal thr; R3 full
        '{64'h0808_0808_0808_0808, 3'b000, 1'b1, 1'b1, 3'd0}, // R7 pop 2
        '{64'h0808_0808_0808_0808, 3'b000, 1'b0, 1'b1, 3'd0}, // R7 2 re-appended
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd1},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd3},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd4},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd5},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd6},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd7},
        '{64'h0, 3'b000, 1'b1, 1'b1, 3'd2},                   // R10 ch2 last
        '{64'h0, 3'b000, 1'b1, 1'b0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] fill_lvl, thresh;
    logic [7:0]  xfer_en;
    logic [2:0]  vid_done;
    logic        pop;
    logic [2:0]  head_id;
    logic        not_empty;
    int          n_chk = 0;
    int          n_err = 0;
    bit          finished = 1'b0;

    chan_req_queue dut_i (
        .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .thresh(thresh),
        .xfer_en(xfer_en), .vid_done(vid_done), .pop(pop),
        .head_id(head_id), .not_empty(not_empty));

    always #(PERIOD / 2) clk = ~clk;

    task automatic step(input logic [63:0] f, input logic [2:0] d, input logic p);
        fill_lvl = f; vid_done = d; pop = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_q(input string req, input logic ne, input logic [2:0] hd);
        n_chk++;
        if (not_empty !== ne || (ne && head_id !== hd)) begin
            n_err++;
            $display("FAIL %s: got ne=%0b head=%0d, expected ne=%0b head=%0d",
                     req, not_empty, head_id, ne, hd);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; fill_lvl = '0; thresh = {8{8'h08}};
        xfer_en = '1; vid_done = '0; pop = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        expect_q("R1 reset empty", 1'b0, 3'd0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].fill, VECS[i].done, VECS[i].pop);
            expect_q($sformatf("R4 vector %0d", i), VECS[i].ne, VECS[i].head);
        end

        // R8 disabled channel is not appended
        xfer_en[5] = 1'b0;
        step(64'h0010_0000_0000_0000 >> 8, 3'b000, 1'b0);
        expect_q("R8 disabled not appended", 1'b0, 3'd0);
        xfer_en[5] = 1'b1;
        step(64'h0000_1000_0000_0000, 3'b000, 1'b0);
        expect_q("R8 enabled appended", 1'b1, 3'd5);
        xfer_en[5] = 1'b0;
        step(64'h0, 3'b000, 1'b0);
        expect_q("R8 queued entry kept", 1'b1, 3'd5);
        xfer_en[5] = 1'b1;
        step(64'h0, 3'b000, 1'b1);
        expect_q("R8 drained", 1'b0, 3'd0);

        // R6 pulse with empty FIFO leaves nothing pending
        step(64'h0, 3'b010, 1'b0);
        step(64'h0000_0000_0000_0400, 3'b000, 1'b0);
        expect_q("R6 pending cleared on empty", 1'b0, 3'd0);
        step(64'h0, 3'b000, 1'b0);

        // R6 flush held across a locked period, then appended
        step(64'h0000_0000_0000_0010, 3'b000, 1'b0);
        expect_q("R6 ch0 queued", 1'b1, 3'd0);
        step(64'h0000_0000_0000_0004, 3'b001, 1'b0);
        expect_q("R6 locked no second entry", 1'b1, 3'd0);
        step(64'h0000_0000_0000_0004, 3'b000, 1'b1);
        expect_q("R7 popped, not yet re-appended", 1'b0, 3'd0);
        step(64'h0000_0000_0000_0004, 3'b000, 1'b0);
        expect_q("R6 held flush appended", 1'b1, 3'd0);
        step(64'h0, 3'b000, 1'b1);
        expect_q("R6 drained", 1'b0, 3'd0);

        // R2 boundary: one below threshold, then a programmed low threshold
        step(64'h0000_0007_0000_0000, 3'b000, 1'b0);
        expect_q("R2 below threshold", 1'b0, 3'd0);
        thresh[39:32] = 8'h02;
        step(64'h0000_0002_0000_0000, 3'b000, 1'b0);
        expect_q("R2 programmed threshold", 1'b1, 3'd4);

        // R1 reset mid-run empties the queue
        rst_n = 1'b0;
        step(64'h0, 3'b000, 1'b0);
        rst_n = 1'b1;
        expect_q("R1 reset clears queue", 1'b0, 3'd0);
        step(64'h0000_0002_0000_0000, 3'b000, 1'b0);
        expect_q("R1 lock cleared by reset", 1'b1, 3'd4);

        finish_run();
    end
endmodule